// File: doc/BRIEF.md
# Clock-Divided Asynchronous Transmitter Engine

This block turns one byte from a transmit holding register into an asynchronous serial frame on a single output line. It does not count system clocks for its bit timing. It moves forward only on cycles where an external transmit-clock tick is asserted, and it holds each bit for a selectable number of those ticks. A frame is a low start bit, then seven or eight data bits sent least significant bit first, then an optional even or odd parity bit, then one or two high stop bits. A 3-bit format code chooses the data width, the parity and the stop-bit count together.

The surrounding status logic owns the "holding register empty" flag. The engine only reads that flag. When it takes the byte into its shift register, it returns a one-cycle strobe so the owner can set the flag again. A frame starts only on a tick where the engine is idle, a byte is waiting and the clear-to-send input (active low) allows it. Clear-to-send is not sampled once a frame is running. Format and divide inputs must stay stable while a frame is in flight.

Top module: `async_tx_engine`

## Requirements
- R1: While reset is low and in the cycle after it, `txd` is 1 and `tdre_set` is 0. A reset in the middle of a frame returns the line to 1 at once.
- R2: A frame starts on an idle tick when `tdr_empty`=0, `cts_n`=0 and `div_sel`!=3. In the clock cycle after that tick, `txd` is 0 and `tdre_set` is 1. `tdre_set` is 1 for exactly that one cycle.
- R3: An idle tick with `cts_n`=1 or `tdr_empty`=1 starts nothing. `txd` stays 1 and `tdre_set` stays 0.
- R4: `div_sel` codes: 0 gives 1 tick per bit, 1 gives 16 ticks per bit, 2 gives 64 ticks per bit. Code 3 lets no frame start.
- R5: Each bit lasts exactly the selected number of ticks, measured from the start tick. `txd` and `tdre_set` change only in the cycle after a tick.
- R6: Data bits leave least significant bit first. Data bit k appears after tick (k+1)·D, counting the start tick as tick 0, where D is the divide ratio.
- R7: `fmt_sel` encoding (data bits, parity, stop bits): 0=7,even,2; 1=7,odd,2; 2=7,even,1; 3=7,odd,1; 4=8,none,2; 5=8,none,1; 6=8,even,1; 7=8,odd,1.
- R8: The parity bit directly follows the last data bit. It is the XOR of the sent data bits for even parity and the inverse of that XOR for odd parity.
- R9: After the last data or parity bit, `txd` stays 1 for (stop bits)·D ticks. A byte that becomes ready during that time starts on the tick right after it, and never earlier.
- R10: `cts_n` only gates the start. Raising it during a frame does not change that frame.
- R11: In the 7-bit formats, bit 7 of `tx_byte` is never sent and does not affect parity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle transmit-clock tick enable |
| tx_byte | input | 8 | Byte in the transmit holding register |
| tdr_empty | input | 1 | Holding register empty flag (0 = byte waiting) |
| cts_n | input | 1 | Clear to send, active low |
| fmt_sel | input | 3 | Word format code (see R7) |
| div_sel | input | 2 | Divide ratio code (see R4) |
| tdre_set | output | 1 | One-cycle strobe: byte taken, set the empty flag |
| txd | output | 1 | Serial output, idle high |

## Verification
The bound checker watches these rules on every clock cycle:
- the output line stays 1 after reset;
- the output line changes only in the cycle after a tick;
- the take strobe is a single-cycle pulse, always paired with a low start bit;
- the take strobe only follows a tick where a byte was waiting, clear-to-send was low and the divide code was not parked.

The checker cannot show the bit order, the parity value, the exact bit and stop-bit lengths for each format and divide ratio, or the back-to-back start timing. Only the bench's frame scenarios show those, by comparing every tick against the expected waveform.

// File: rtl/atx_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the asynchronous transmitter engine.
// Assumes: nothing beyond IEEE 1800-2017.
package atx_pkg;

    // Engine phase: idle/start check, data+parity shifting, stop bits.
    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_DATA = 2'd1,
        TX_STOP = 2'd2
    } tx_phase_t;

    // Decoded word format.
    typedef struct packed {
        logic eight;     // 1: eight data bits, 0: seven
        logic par_en;    // parity bit present
        logic par_odd;   // odd parity when par_en
        logic two_stop;  // two stop bits
    } tx_fmt_t;

endpackage

// File: rtl/atx_fmt_decode.sv
`timescale 1ns/1ps
// Module: atx_fmt_decode
// Turns the 3-bit word format code into data width, parity and stop-bit
// fields. Purely combinational. Assumes the code is stable during a frame.
module atx_fmt_decode
    import atx_pkg::*;
(
    input  logic [2:0] fmt_sel,
    output tx_fmt_t    fmt
);

    // Format table lookup.
    always_comb begin
        unique case (fmt_sel)
            3'd0:    fmt = '{eight: 1'b0, par_en: 1'b1, par_odd: 1'b0, two_stop: 1'b1};
            3'd1:    fmt = '{eight: 1'b0, par_en: 1'b1, par_odd: 1'b1, two_stop: 1'b1};
            3'd2:    fmt = '{eight: 1'b0, par_en: 1'b1, par_odd: 1'b0, two_stop: 1'b0};
            3'd3:    fmt = '{eight: 1'b0, par_en: 1'b1, par_odd: 1'b1, two_stop: 1'b0};
            3'd4:    fmt = '{eight: 1'b1, par_en: 1'b0, par_odd: 1'b0, two_stop: 1'b1};
            3'd5:    fmt = '{eight: 1'b1, par_en: 1'b0, par_odd: 1'b0, two_stop: 1'b0};
            3'd6:    fmt = '{eight: 1'b1, par_en: 1'b1, par_odd: 1'b0, two_stop: 1'b0};
            default: fmt = '{eight: 1'b1, par_en: 1'b1, par_odd: 1'b1, two_stop: 1'b0};
        endcase
    end

endmodule

// File: rtl/atx_rate_sel.sv
`timescale 1ns/1ps
// Module: atx_rate_sel
// Maps the 2-bit divide code to a "ticks per bit minus one" terminal count
// and a park flag (code 3) that blocks new frames.
// Assumes: every ratio parameter is between 1 and 2**CNT_W.
module atx_rate_sel #(
    parameter int DIV_LO  = 1,
    parameter int DIV_MID = 16,
    parameter int DIV_HI  = 64,
    parameter int CNT_W   = 7
) (
    input  logic [1:0]       div_sel,
    output logic [CNT_W-1:0] ratio_m1,
    output logic             park
);

    localparam logic [CNT_W-1:0] LO_M1  = CNT_W'(DIV_LO - 1);
    localparam logic [CNT_W-1:0] MID_M1 = CNT_W'(DIV_MID - 1);
    localparam logic [CNT_W-1:0] HI_M1  = CNT_W'(DIV_HI - 1);

    // Terminal count and park decode.
    always_comb begin
        park = 1'b0;
        unique case (div_sel)
            2'd0:    ratio_m1 = LO_M1;
            2'd1:    ratio_m1 = MID_M1;
            2'd2:    ratio_m1 = HI_M1;
            default: begin
                ratio_m1 = HI_M1;
                park     = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/atx_bit_timer.sv
`timescale 1ns/1ps
// Module: atx_bit_timer
// Counts transmit-clock ticks within one bit. It is held at zero while
// run is low. bit_end marks the tick that completes a bit period.
// Assumes: ratio_m1 does not change while run is high.
module atx_bit_timer #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] ratio_m1,
    output logic             bit_end
);

    logic [CNT_W-1:0] cnt;

    assign bit_end = run && tick && (cnt == ratio_m1);

    // Tick counter: clear when idle or at end of bit, else count ticks.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (bit_end) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/atx_shifter.sv
`timescale 1ns/1ps
// Module: atx_shifter
// Right-shifting data register with a running XOR of every bit shifted out.
// load has priority over step.
// Assumes: a step never comes in the same cycle as a load.
module atx_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         step,
    output logic         lsb,
    output logic         par_acc
);

    logic [W-1:0] sr;

    assign lsb = sr[0];

    // Shift register and parity accumulator update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr      <= '0;
            par_acc <= 1'b0;
        end else if (load) begin
            sr      <= load_data;
            par_acc <= 1'b0;
        end else if (step) begin
            sr      <= {1'b0, sr[W-1:1]};
            par_acc <= par_acc ^ sr[0];
        end
    end

endmodule

// File: rtl/async_tx_engine.sv
`timescale 1ns/1ps
// Module: async_tx_engine
// Tick-driven asynchronous transmitter. On an idle tick with a byte waiting
// and clear-to-send low, it loads the byte, pulses tdre_set and drives the
// start bit. It then sends the data bits LSB first, an optional parity bit
// and one or two stop bits, each held for the selected number of ticks.
// Assumes: fmt_sel and div_sel are stable while a frame is in flight, and
// tick is a single-cycle enable synchronous to clk.
module async_tx_engine #(
    parameter int DIV_LO  = 1,
    parameter int DIV_MID = 16,
    parameter int DIV_HI  = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [7:0] tx_byte,
    input  logic       tdr_empty,
    input  logic       cts_n,
    input  logic [2:0] fmt_sel,
    input  logic [1:0] div_sel,
    output logic       tdre_set,
    output logic       txd
);
    import atx_pkg::*;

    localparam int CNT_W  = $clog2(DIV_HI + 1);
    localparam int BYTE_W = 8;
    localparam int IDX_W  = $clog2(BYTE_W + 2);

    tx_phase_t          phase;
    logic [IDX_W-1:0]   bit_idx;
    tx_fmt_t            fmt;
    logic [CNT_W-1:0]   ratio_m1;
    logic               park;
    logic               bit_end;
    logic               sh_lsb;
    logic               sh_par;
    logic               start_go;
    logic               step;
    logic [IDX_W-1:0]   data_bits;
    logic [IDX_W-1:0]   last_stop;

    atx_fmt_decode u_fmt (
        .fmt_sel (fmt_sel),
        .fmt     (fmt)
    );

    atx_rate_sel #(
        .DIV_LO  (DIV_LO),
        .DIV_MID (DIV_MID),
        .DIV_HI  (DIV_HI),
        .CNT_W   (CNT_W)
    ) u_rate (
        .div_sel  (div_sel),
        .ratio_m1 (ratio_m1),
        .park     (park)
    );

    atx_bit_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (phase != TX_IDLE),
        .tick     (tick),
        .ratio_m1 (ratio_m1),
        .bit_end  (bit_end)
    );

    atx_shifter #(
        .W (BYTE_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start_go),
        .load_data (tx_byte),
        .step      (step),
        .lsb       (sh_lsb),
        .par_acc   (sh_par)
    );

    // Per-format counts and handshake qualifiers.
    assign data_bits = fmt.eight ? IDX_W'(BYTE_W) : IDX_W'(BYTE_W - 1);
    assign last_stop = fmt.two_stop ? IDX_W'(1) : IDX_W'(0);
    assign start_go  = (phase == TX_IDLE) && tick && !tdr_empty && !cts_n && !park;
    assign step      = (phase == TX_DATA) && bit_end && (bit_idx < data_bits);

    // Frame sequencer: start bit, data, parity, stop bits, back to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= TX_IDLE;
            bit_idx  <= '0;
            txd      <= 1'b1;
            tdre_set <= 1'b0;
        end else begin
            tdre_set <= 1'b0;
            unique case (phase)
                TX_IDLE: begin
                    bit_idx <= '0;
                    if (start_go) begin
                        phase    <= TX_DATA;
                        txd      <= 1'b0;
                        tdre_set <= 1'b1;
                    end else begin
                        txd <= 1'b1;
                    end
                end
                TX_DATA: begin
                    if (bit_end) begin
                        if (bit_idx < data_bits) begin
                            txd     <= sh_lsb;
                            bit_idx <= bit_idx + 1'b1;
                        end else if (bit_idx == data_bits && fmt.par_en) begin
                            txd     <= sh_par ^ fmt.par_odd;
                            bit_idx <= bit_idx + 1'b1;
                        end else begin
                            txd     <= 1'b1;
                            phase   <= TX_STOP;
                            bit_idx <= '0;
                        end
                    end
                end
                TX_STOP: begin
                    if (bit_end) begin
                        if (bit_idx == last_stop) begin
                            phase   <= TX_IDLE;
                            bit_idx <= '0;
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                        end
                    end
                end
                default: begin
                    phase <= TX_IDLE;
                    txd   <= 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/async_tx_engine_chk.sv
`timescale 1ns/1ps
// Module: async_tx_engine_chk
// Port-level protocol checks for async_tx_engine, attached by bind.
module async_tx_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       tdr_empty,
    input logic       cts_n,
    input logic [1:0] div_sel,
    input logic       tdre_set,
    input logic       txd
);

    // R1
    reset_mark_chk: assert property (@(posedge clk)
        !rst_n |=> (txd && !tdre_set));

    // R5
    tick_paced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(txd) |-> ($past(tick) || !$past(rst_n)));

    // R2
    strobe_start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tdre_set |-> !txd);

    // R2
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tdre_set |=> !tdre_set);

    // R3
    start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tdre_set |-> ($past(tick) && !$past(cts_n) && !$past(tdr_empty)));

    // R4
    park_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(div_sel) == 2'd3) |-> !tdre_set);

endmodule

bind async_tx_engine async_tx_engine_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .tdr_empty (tdr_empty),
    .cts_n     (cts_n),
    .div_sel   (div_sel),
    .tdre_set  (tdre_set),
    .txd       (txd)
);

// File: tb/test_async_tx_engine.sv
`timescale 1ns/1ps
// Bench for async_tx_engine: directed corner cases plus seeded random frames,
// each compared tick by tick against a waveform computed from the requirements.
module test_async_tx_engine;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic       tdr_empty = 1'b1;
    logic       cts_n = 1'b1;
    logic [2:0] fmt_sel = 3'd0;
    logic [1:0] div_sel = 2'd0;
    logic       tdre_set;
    logic       txd;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  gap_bad  = 1'b0;
    logic last_txd = 1'b1;

    always #4 clk = ~clk;

    async_tx_engine i_async_tx_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .tx_byte   (tx_byte),
        .tdr_empty (tdr_empty),
        .cts_n     (cts_n),
        .fmt_sel   (fmt_sel),
        .div_sel   (div_sel),
        .tdre_set  (tdre_set),
        .txd       (txd)
    );

    // Record one check; print a FAIL line on mismatch.
    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Model: ticks per bit for a divide code (R4).
    function automatic int div_of(input logic [1:0] d);
        case (d)
            2'd0:    return 1;
            2'd1:    return 16;
            default: return 64;
        endcase
    endfunction

    // Model: start + data + parity slot count (R7).
    function automatic int payload_slots(input logic [2:0] f);
        int nb;
        int pe;
        nb = f[2] ? 8 : 7;
        pe = (f[2] && !f[1]) ? 0 : 1;
        return 1 + nb + pe;
    endfunction

    // Model: stop bit count (R7).
    function automatic int stop_of(input logic [2:0] f);
        return (!f[1] && !(f[2] && f[0])) ? 2 : 1;
    endfunction

    // Model: expected line level in a given bit slot (R6, R8, R11).
    function automatic logic exp_txd(input logic [7:0] b, input logic [2:0] f,
                                     input int slot);
        int   nb;
        logic pe;
        logic pv;
        nb = f[2] ? 8 : 7;
        pe = !(f[2] && !f[1]);
        pv = f[0];
        for (int j = 0; j < nb; j++) pv ^= b[j];
        if (slot == 0) return 1'b0;
        if (slot <= nb) return b[slot-1];
        if (pe && slot == nb + 1) return pv;
        return 1'b1;
    endfunction

    // One tick with random idle clocks before it; sample after the tick edge.
    task automatic do_tick(output logic t, output logic s);
        int g;
        g = $urandom_range(0, 2);
        for (int k = 0; k < g; k++) begin
            @(negedge clk);
            if (txd !== last_txd || tdre_set !== 1'b0) gap_bad = 1'b1;
        end
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        t = txd;
        s = tdre_set;
        last_txd = txd;
    endtask

    // Send one frame and compare every tick; optionally present the next byte
    // as soon as the stop phase begins (chain).
    task automatic run_frame(input logic [7:0] b, input logic [2:0] f,
                             input logic [1:0] d, input bit cts_mid,
                             input bit chain, input logic [7:0] nxt,
                             input string tag);
        logic t;
        logic s;
        int   dv;
        int   p;
        int   tot;
        int   slot;
        bit   bad;
        logic bad_t;
        logic bad_e;
        logic e;
        tx_byte   = b;
        fmt_sel   = f;
        div_sel   = d;
        tdr_empty = 1'b0;
        cts_n     = 1'b0;
        gap_bad   = 1'b0;
        do_tick(t, s);
        check(t === 1'b0 && s === 1'b1, "R2 start bit and strobe", {t, s}, 2'b01);
        tdr_empty = 1'b1;
        dv  = div_of(d);
        p   = payload_slots(f);
        tot = (p + stop_of(f)) * dv;
        bad = 1'b0;
        bad_t = 1'b0;
        bad_e = 1'b0;
        for (int i = 1; i <= tot; i++) begin
            if (cts_mid && i == 2) cts_n = 1'b1;
            do_tick(t, s);
            slot = i / dv;
            e = (slot < p) ? exp_txd(b, f, slot) : 1'b1;
            if ((t !== e || s !== 1'b0) && !bad) begin
                bad   = 1'b1;
                bad_t = t;
                bad_e = e;
                $display("  mismatch at tick %0d of frame (%s)", i, tag);
            end
            if (chain && i == p * dv) begin
                tx_byte   = nxt;
                tdr_empty = 1'b0;
                cts_n     = 1'b0;
            end
        end
        check(!bad && !gap_bad, tag, {31'd0, bad_t}, {31'd0, bad_e});
        if (!chain) begin
            do_tick(t, s);
            check(t === 1'b1 && s === 1'b0, "R9 idle after stop phase", {t, s}, 2'b10);
        end
    endtask

    // Several idle ticks that must not start a frame.
    task automatic expect_idle(input int n, input string tag);
        logic t;
        logic s;
        bit   bad;
        bad = 1'b0;
        for (int i = 0; i < n; i++) begin
            do_tick(t, s);
            if (t !== 1'b1 || s !== 1'b0) bad = 1'b1;
        end
        check(!bad && !gap_bad, tag, {t, s}, 2'b10);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (190000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic t;
        logic s;
        logic [7:0] b;
        logic [7:0] nb;
        logic [2:0] f;
        logic [1:0] d;
        bit         ch;
        void'($urandom(32'd7177));

        // R1: reset state
        repeat (3) @(negedge clk);
        check(txd === 1'b1 && tdre_set === 1'b0, "R1 during reset", {txd, tdre_set}, 2'b10);
        rst_n = 1'b1;
        @(negedge clk);
        check(txd === 1'b1 && tdre_set === 1'b0, "R1 after reset", {txd, tdre_set}, 2'b10);
        last_txd = txd;

        // R3: blocked by CTS, then by an empty holding register
        tx_byte = 8'h5A; fmt_sel = 3'd5; div_sel = 2'd0;
        tdr_empty = 1'b0; cts_n = 1'b1; gap_bad = 1'b0;
        expect_idle(6, "R3 cts_n high blocks start");
        tdr_empty = 1'b1; cts_n = 1'b0;
        expect_idle(6, "R3 empty register blocks start");

        // R4: park code blocks start even when ready
        tdr_empty = 1'b0; cts_n = 1'b0; div_sel = 2'd3;
        expect_idle(6, "R4 divide code 3 parks engine");

        // Directed frames over formats and ratios
        run_frame(8'hA5, 3'd5, 2'd0, 1'b0, 1'b0, 8'h00, "R6 R7 8N1 ratio 1");
        run_frame(8'h3C, 3'd0, 2'd1, 1'b0, 1'b0, 8'h00, "R5 R8 7E2 ratio 16");
        run_frame(8'h0B, 3'd7, 2'd2, 1'b0, 1'b0, 8'h00, "R4 R8 8O1 ratio 64");
        run_frame(8'h80, 3'd2, 2'd0, 1'b0, 1'b0, 8'h00, "R11 7E1 bit7 ignored");
        run_frame(8'hFF, 3'd3, 2'd1, 1'b0, 1'b0, 8'h00, "R11 R8 7O1 all ones");
        run_frame(8'h01, 3'd4, 2'd0, 1'b1, 1'b0, 8'h00, "R10 cts raised mid-frame 8N2");
        run_frame(8'hC3, 3'd1, 2'd0, 1'b0, 1'b1, 8'h96, "R9 7O2 byte during stop");
        run_frame(8'h96, 3'd1, 2'd0, 1'b0, 1'b0, 8'h00, "R9 R7 back-to-back second frame");
        run_frame(8'h6E, 3'd6, 2'd1, 1'b0, 1'b1, 8'h11, "R9 8E1 ratio 16 chained");
        run_frame(8'h11, 3'd6, 2'd1, 1'b0, 1'b0, 8'h00, "R9 R5 chained start timing");

        // R1: reset in the middle of a frame
        tx_byte = 8'h00; fmt_sel = 3'd5; div_sel = 2'd1;
        tdr_empty = 1'b0; cts_n = 1'b0;
        do_tick(t, s);
        tdr_empty = 1'b1;
        repeat (5) do_tick(t, s);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check(txd === 1'b1 && tdre_set === 1'b0, "R1 reset mid-frame", {txd, tdre_set}, 2'b10);
        last_txd = txd; gap_bad = 1'b0;
        expect_idle(4, "R1 idle after mid-frame reset");

        // Random frames, some chained with the same format and ratio
        b = 8'($urandom); f = 3'($urandom_range(0, 7)); d = 2'($urandom_range(0, 1));
        for (int k = 0; k < 40; k++) begin
            ch = (k < 39) && ($urandom_range(0, 2) == 0);
            nb = 8'($urandom);
            run_frame(b, f, d, 1'b0, ch, nb, "R5 R6 R7 R8 random frame");
            if (ch) begin
                b = nb;
            end else begin
                b = 8'($urandom); f = 3'($urandom_range(0, 7)); d = 2'($urandom_range(0, 1));
            end
        end

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule